// File: doc/BRIEF.md
# Synchronous Transfer Agreement Responder

This block sits on the target side of a parallel SCSI controller and settles how fast and how far ahead data may run in the data phases. It watches the message bytes an initiator sends during message-out, recognises an extended synchronous-transfer request, and turns the requested period factor and REQ/ACK offset into an agreement the target can honour. Exactly two synchronous rates exist: factor 25 (10 MB/s) and factor 50 (5 MB/s). Anything slower becomes asynchronous transfer.

The agreement is stored per target ID and echoed back to the initiator as a five-byte extended message for the message-in phase. After the echo, the target waits to see whether the initiator rejects it. A reject in that window reverts the agreement to asynchronous. The end of the exchange with ATN released, or the start of a new selection, closes the window. Bus reset clears every target's agreement. A device-reset message clears the agreement of the selected target only. The data-phase engine reads the agreed period and offset for the selected target straight from the outputs.

Top module: `sdtr_responder`

## Requirements
- R1: After reset every target's agreement is period 0, offset 0, and no reply byte is driven.
- R2: A request whose period factor exceeds 50 yields period 0 and offset 0. The reply carries those zeros.
- R3: A request period factor of 25 or less is agreed as 25. A factor from 26 to 50 is agreed as 50.
- R4: The agreed offset is the requested offset limited to at most 15.
- R5: The reply is driven on five consecutive cycles, starting the cycle after the offset byte is taken. The bytes, in order, are 0x01, 0x03, 0x01, agreed period, agreed offset.
- R6: A request is recognised only as the byte sequence 0x01, length 0x03, code 0x01, period, offset. Any other extended message is skipped by its length byte (0 meaning 256), produces no reply and leaves the agreement unchanged. Stray non-0x01 bytes between messages are ignored.
- R7: A message reject that arrives after the reply has been fully sent, with the window still open, reverts the selected target to period 0, offset 0. A reject with no open window changes nothing.
- R8: An exchange-done pulse with ATN low closes the window, so a later reject changes nothing. With ATN high the window stays open.
- R9: A bus reset pulse clears the agreements of all targets.
- R10: A device-reset message pulse clears only the selected target's agreement.
- R11: A selection pulse makes `sel_id` the current target, whose stored agreement then appears on the outputs. A selection also closes the reject window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | Message-out byte strobe |
| msg_byte | input | 8 | Message-out byte |
| atn | input | 1 | ATN level from the bus |
| xchg_done | input | 1 | Pulse: message exchange finished |
| msg_reject | input | 1 | Pulse: initiator sent message reject |
| bus_reset | input | 1 | Pulse: SCSI bus reset seen |
| dev_reset | input | 1 | Pulse: bus-device-reset message received |
| sel_valid | input | 1 | Pulse: selection of a new target begins |
| sel_id | input | ID_W | Target ID being selected |
| rsp_valid | output | 1 | Reply byte valid |
| rsp_byte | output | 8 | Reply byte for message-in |
| agr_period | output | 8 | Agreed period factor of the selected target |
| agr_offset | output | 8 | Agreed REQ/ACK offset of the selected target |

## Verification
The request is driven with period factors on both sides of each quantisation edge: 10, 25, 26, 40, 50, 51 and 255. These separate the fast, slow and asynchronous outcomes. Offsets below, at and far above the cap of 15 show whether the limit is applied. Extended messages with a wrong length or a wrong code check that the parser keeps alignment and stays silent. The bench then sends a valid request right after them. Reject is tried in three ways: inside the window, after a clean exchange, and after a reselection. This separates a correct window from one that is always open or always closed. Two targets hold different values, so the per-target storage and the scope of both reset kinds can be told apart.

// File: rtl/sdtr_pkg.sv
package sdtr_pkg;

    localparam int          BYTE_W      = 8;
    localparam logic [7:0]  EXT_MSG     = 8'h01;
    localparam logic [7:0]  SDTR_LEN    = 8'h03;
    localparam logic [7:0]  SDTR_CODE   = 8'h01;
    localparam logic [7:0]  FAST_FACTOR = 8'd25;
    localparam logic [7:0]  SLOW_FACTOR = 8'd50;
    localparam logic [7:0]  MAX_OFFSET  = 8'd15;
    localparam int          REPLY_LEN   = 5;
    localparam int          REPLY_CW    = $clog2(REPLY_LEN);

    typedef struct packed {
        logic [BYTE_W-1:0] period;
        logic [BYTE_W-1:0] offset;
    } agree_t;

    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_LEN  = 2'd1,
        PS_BODY = 2'd2
    } pstate_e;

    function automatic agree_t decide(input logic [7:0] req_p, input logic [7:0] req_o);
        agree_t r;
        if (req_p > SLOW_FACTOR) begin
            r.period = '0;
            r.offset = '0;
        end else begin
            r.period = (req_p <= FAST_FACTOR) ? FAST_FACTOR : SLOW_FACTOR;
            r.offset = (req_o > MAX_OFFSET) ? MAX_OFFSET : req_o;
        end
        return r;
    endfunction

endpackage

// File: rtl/sdtr_parser.sv
module sdtr_parser
    import sdtr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        abort,
    input  logic        msg_valid,
    input  logic [7:0]  msg_byte,
    output logic        req_fire,
    output agree_t      req_raw
);
    pstate_e     state_q;
    logic [7:0]  len_q;
    logic [8:0]  left_q;
    logic [1:0]  idx_q;
    logic [7:0]  code_q;
    logic [7:0]  per_q;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            state_q <= PS_IDLE;
            len_q   <= '0;
            left_q  <= '0;
            idx_q   <= '0;
            code_q  <= '0;
            per_q   <= '0;
        end else if (msg_valid) begin
            case (state_q)
                PS_IDLE: begin
                    if (msg_byte == EXT_MSG) state_q <= PS_LEN;
                end
                PS_LEN: begin
                    len_q   <= msg_byte;
                    left_q  <= (msg_byte == 8'd0) ? 9'd256 : {1'b0, msg_byte};
                    idx_q   <= '0;
                    state_q <= PS_BODY;
                end
                PS_BODY: begin
                    if (idx_q == 2'd0) code_q <= msg_byte;
                    if (idx_q == 2'd1) per_q  <= msg_byte;
                    if (idx_q != 2'd3) idx_q  <= idx_q + 2'd1;
                    left_q <= left_q - 9'd1;
                    if (left_q == 9'd1) state_q <= PS_IDLE;
                end
                default: state_q <= PS_IDLE;
            endcase
        end
    end

    always_comb begin
        req_fire = msg_valid && (state_q == PS_BODY) && (left_q == 9'd1) &&
                   (idx_q == 2'd2) && (len_q == SDTR_LEN) && (code_q == SDTR_CODE);
        req_raw.period = per_q;
        req_raw.offset = msg_byte;
    end

endmodule

// File: rtl/sdtr_table.sv
module sdtr_table
    import sdtr_pkg::*;
#(
    parameter int NUM_TGT = 8,
    parameter int ID_W    = $clog2(NUM_TGT)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr_all,
    input  logic            clr_one,
    input  logic [ID_W-1:0] clr_id,
    input  logic            wr_en,
    input  logic [ID_W-1:0] wr_id,
    input  agree_t          wr_data,
    input  logic [ID_W-1:0] rd_id,
    output agree_t          rd_data
);
    agree_t ent [NUM_TGT];

    for (genvar g = 0; g < NUM_TGT; g++) begin : g_ent
        agree_t ent_q;
        always_ff @(posedge clk) begin
            if (rst || clr_all) begin
                ent_q <= '0;
            end else if (clr_one && (clr_id == ID_W'(g))) begin
                ent_q <= '0;
            end else if (wr_en && (wr_id == ID_W'(g))) begin
                ent_q <= wr_data;
            end
        end
        assign ent[g] = ent_q;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_TGT; i++) begin
            if (rd_id == ID_W'(i)) rd_data = ent[i];
        end
    end

endmodule

// File: rtl/sdtr_reply.sv
module sdtr_reply
    import sdtr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        abort,
    input  logic        start,
    input  agree_t      start_val,
    input  logic        reject,
    input  logic        xchg_done,
    input  logic        atn,
    output logic        rsp_valid,
    output logic [7:0]  rsp_byte,
    output logic        revert
);
    localparam logic [REPLY_CW-1:0] LAST = REPLY_CW'(REPLY_LEN - 1);

    logic                busy_q;
    logic [REPLY_CW-1:0] cnt_q;
    agree_t              val_q;
    logic                pend_q;
    logic                finish;

    assign finish = busy_q && !start && (cnt_q == LAST);
    assign revert = reject && pend_q;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            val_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (start) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
                val_q  <= start_val;
            end else if (busy_q) begin
                if (cnt_q == LAST) busy_q <= 1'b0;
                else               cnt_q  <= cnt_q + 1'b1;
            end

            if (start)                  pend_q <= 1'b0;
            else if (finish)            pend_q <= 1'b1;
            else if (revert)            pend_q <= 1'b0;
            else if (xchg_done && !atn) pend_q <= 1'b0;
        end
    end

    always_comb begin
        rsp_valid = busy_q;
        case (cnt_q)
            REPLY_CW'(0): rsp_byte = EXT_MSG;
            REPLY_CW'(1): rsp_byte = SDTR_LEN;
            REPLY_CW'(2): rsp_byte = SDTR_CODE;
            REPLY_CW'(3): rsp_byte = val_q.period;
            REPLY_CW'(4): rsp_byte = val_q.offset;
            default:      rsp_byte = '0;
        endcase
    end

endmodule

// File: rtl/sdtr_responder.sv
module sdtr_responder
    import sdtr_pkg::*;
#(
    parameter int NUM_TGT = 8,
    parameter int ID_W    = $clog2(NUM_TGT)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            msg_valid,
    input  logic [7:0]      msg_byte,
    input  logic            atn,
    input  logic            xchg_done,
    input  logic            msg_reject,
    input  logic            bus_reset,
    input  logic            dev_reset,
    input  logic            sel_valid,
    input  logic [ID_W-1:0] sel_id,
    output logic            rsp_valid,
    output logic [7:0]      rsp_byte,
    output logic [7:0]      agr_period,
    output logic [7:0]      agr_offset
);
    logic [ID_W-1:0] cur_id_q;
    logic            req_fire;
    agree_t          req_raw;
    agree_t          agreed;
    agree_t          cur_val;
    logic            fire_ok;
    logic            revert;

    always_ff @(posedge clk) begin
        if (rst)            cur_id_q <= '0;
        else if (sel_valid) cur_id_q <= sel_id;
    end

    sdtr_parser u_parser (
        .clk       (clk),
        .rst       (rst),
        .abort     (bus_reset | sel_valid),
        .msg_valid (msg_valid),
        .msg_byte  (msg_byte),
        .req_fire  (req_fire),
        .req_raw   (req_raw)
    );

    assign agreed  = decide(req_raw.period, req_raw.offset);
    assign fire_ok = req_fire && !bus_reset && !sel_valid && !dev_reset;

    sdtr_table #(.NUM_TGT(NUM_TGT), .ID_W(ID_W)) u_table (
        .clk     (clk),
        .rst     (rst),
        .clr_all (bus_reset),
        .clr_one (dev_reset | revert),
        .clr_id  (cur_id_q),
        .wr_en   (fire_ok),
        .wr_id   (cur_id_q),
        .wr_data (agreed),
        .rd_id   (cur_id_q),
        .rd_data (cur_val)
    );

    sdtr_reply u_reply (
        .clk       (clk),
        .rst       (rst),
        .abort     (bus_reset | sel_valid | dev_reset),
        .start     (fire_ok),
        .start_val (agreed),
        .reject    (msg_reject),
        .xchg_done (xchg_done),
        .atn       (atn),
        .rsp_valid (rsp_valid),
        .rsp_byte  (rsp_byte),
        .revert    (revert)
    );

    assign agr_period = cur_val.period;
    assign agr_offset = cur_val.offset;

endmodule

// File: rtl/sdtr_checker.sv
module sdtr_checker
    import sdtr_pkg::*;
#(
    parameter int ID_W = 3
) (
    input logic            clk,
    input logic            rst,
    input logic            msg_valid,
    input logic            msg_reject,
    input logic            bus_reset,
    input logic            dev_reset,
    input logic            sel_valid,
    input logic [ID_W-1:0] sel_id,
    input logic            rsp_valid,
    input logic [7:0]      rsp_byte,
    input logic [7:0]      agr_period,
    input logic [7:0]      agr_offset
);
    p_bus_reset_clears_r9: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> (agr_period == 8'd0) && (agr_offset == 8'd0));

    p_offset_cap_r4: assert property (@(posedge clk) disable iff (rst)
        agr_offset <= MAX_OFFSET);

    p_period_legal_r3: assert property (@(posedge clk) disable iff (rst)
        (agr_period == 8'd0) || (agr_period == FAST_FACTOR) || (agr_period == SLOW_FACTOR));

    p_async_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (agr_period == 8'd0) |-> (agr_offset == 8'd0));

    p_reply_head_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(rsp_valid) |-> (rsp_byte == EXT_MSG));

    p_dev_reset_r10: assert property (@(posedge clk) disable iff (rst)
        (dev_reset && !bus_reset && !sel_valid) |=> (agr_period == 8'd0) && (agr_offset == 8'd0));

    p_quiet_stable_r6: assert property (@(posedge clk) disable iff (rst)
        (!msg_valid && !msg_reject && !bus_reset && !dev_reset && !sel_valid)
        |=> $stable(agr_period) && $stable(agr_offset));

    p_sel_id_known_r11: assert property (@(posedge clk) disable iff (rst)
        sel_valid |-> !$isunknown(sel_id));

endmodule

bind sdtr_responder sdtr_checker #(.ID_W(ID_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .msg_valid  (msg_valid),
    .msg_reject (msg_reject),
    .bus_reset  (bus_reset),
    .dev_reset  (dev_reset),
    .sel_valid  (sel_valid),
    .sel_id     (sel_id),
    .rsp_valid  (rsp_valid),
    .rsp_byte   (rsp_byte),
    .agr_period (agr_period),
    .agr_offset (agr_offset)
);

// File: tb/sdtr_responder_bench.sv
module sdtr_responder_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       msg_valid = 1'b0;
    logic [7:0] msg_byte = '0;
    logic       atn = 1'b0;
    logic       xchg_done = 1'b0;
    logic       msg_reject = 1'b0;
    logic       bus_reset = 1'b0;
    logic       dev_reset = 1'b0;
    logic       sel_valid = 1'b0;
    logic [2:0] sel_id = '0;
    logic       rsp_valid;
    logic [7:0] rsp_byte;
    logic [7:0] agr_period;
    logic [7:0] agr_offset;

    int checks = 0;
    int errors = 0;
    int exp_p [8];
    int exp_o [8];
    int cur = 0;
    logic [7:0] exp_q [$];

    always #4 clk = ~clk;

    sdtr_responder u_sdtr_responder (
        .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_byte(msg_byte),
        .atn(atn), .xchg_done(xchg_done), .msg_reject(msg_reject),
        .bus_reset(bus_reset), .dev_reset(dev_reset), .sel_valid(sel_valid),
        .sel_id(sel_id), .rsp_valid(rsp_valid), .rsp_byte(rsp_byte),
        .agr_period(agr_period), .agr_offset(agr_offset)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: pops expected reply bytes as the design produces them
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected reply byte", int'(rsp_byte), -1);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(rsp_byte == e, "R5 reply byte", int'(rsp_byte), int'(e));
            end
        end
    end

    task automatic chk_out(input string tag);
        check(int'(agr_period) == exp_p[cur], {tag, " period"}, int'(agr_period), exp_p[cur]);
        check(int'(agr_offset) == exp_o[cur], {tag, " offset"}, int'(agr_offset), exp_o[cur]);
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        msg_valid = 1'b1;
        msg_byte  = b;
    endtask

    task automatic end_bytes();
        @(negedge clk);
        msg_valid = 1'b0;
        msg_byte  = '0;
    endtask

    task automatic settle(input string tag);
        repeat (6) @(negedge clk);
        check(exp_q.size() == 0, {tag, " reply drained"}, exp_q.size(), 0);
    endtask

    task automatic sdtr(input int p, input int o, input string tag);
        int ap, ao;
        if (p > 50) begin ap = 0; ao = 0; end
        else begin
            ap = (p <= 25) ? 25 : 50;
            ao = (o > 15) ? 15 : o;
        end
        exp_p[cur] = ap;
        exp_o[cur] = ao;
        exp_q.push_back(8'h01);
        exp_q.push_back(8'h03);
        exp_q.push_back(8'h01);
        exp_q.push_back(8'(ap));
        exp_q.push_back(8'(ao));
        send_byte(8'h01);
        send_byte(8'h03);
        send_byte(8'h01);
        send_byte(8'(p));
        send_byte(8'(o));
        end_bytes();
        settle(tag);
        chk_out(tag);
    endtask

    task automatic do_sel(input int id);
        @(negedge clk);
        sel_valid = 1'b1;
        sel_id    = 3'(id);
        @(negedge clk);
        sel_valid = 1'b0;
        cur = id;
    endtask

    task automatic do_xchg(input logic lvl);
        @(negedge clk);
        atn = lvl;
        xchg_done = 1'b1;
        @(negedge clk);
        xchg_done = 1'b0;
        atn = 1'b0;
    endtask

    task automatic do_reject();
        @(negedge clk);
        msg_reject = 1'b1;
        @(negedge clk);
        msg_reject = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 8; i++) begin exp_p[i] = 0; exp_o[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk_out("R1 reset");
        check(rsp_valid == 1'b0, "R1 no reply", int'(rsp_valid), 0);

        do_sel(2);
        chk_out("R11 select empty");
        sdtr(10, 8, "R3 fast");
        sdtr(25, 15, "R3 at fast edge");
        sdtr(26, 15, "R3 just slow");
        sdtr(40, 20, "R4 cap");
        sdtr(50, 3, "R3 slow edge");
        sdtr(51, 5, "R2 just async");
        sdtr(255, 200, "R2 far async");
        sdtr(12, 255, "R4 cap max");

        // R8: clean exchange closes window, then reject ignored (R7)
        sdtr(25, 15, "R8 setup");
        do_xchg(1'b0);
        do_reject();
        @(negedge clk);
        chk_out("R8 reject after atn low");

        // R7 + R8: ATN high keeps window open, reject reverts
        sdtr(20, 4, "R7 setup");
        do_xchg(1'b1);
        do_reject();
        exp_p[cur] = 0; exp_o[cur] = 0;
        @(negedge clk);
        chk_out("R7 reject reverts");

        // R7: reject with no window
        sdtr(30, 6, "R7 setup2");
        do_xchg(1'b0);
        do_reject();
        do_reject();
        @(negedge clk);
        chk_out("R7 reject no window");

        // R6: other extended messages ignored, parser stays aligned
        send_byte(8'h07);
        send_byte(8'h01); send_byte(8'h02); send_byte(8'h03); send_byte(8'h05);
        send_byte(8'h01); send_byte(8'h03); send_byte(8'h02); send_byte(8'd10); send_byte(8'd9);
        send_byte(8'h01); send_byte(8'h04); send_byte(8'h01); send_byte(8'd10);
        send_byte(8'd9);  send_byte(8'd1);
        end_bytes();
        settle("R6 ignored");
        chk_out("R6 unchanged");
        sdtr(22, 2, "R6 realigned");

        // R11: per-target storage
        do_sel(5);
        chk_out("R11 target 5 empty");
        sdtr(12, 7, "R11 target 5");
        do_sel(2);
        chk_out("R11 target 2 kept");
        do_sel(5);
        chk_out("R11 target 5 kept");

        // R11: selection closes reject window
        sdtr(30, 9, "R11 setup");
        do_sel(5);
        do_reject();
        @(negedge clk);
        chk_out("R11 reject after reselect");

        // R10: device reset clears only selected
        @(negedge clk);
        dev_reset = 1'b1;
        @(negedge clk);
        dev_reset = 1'b0;
        exp_p[5] = 0; exp_o[5] = 0;
        chk_out("R10 target 5 cleared");
        do_sel(2);
        chk_out("R10 target 2 kept");

        // R9: bus reset clears all
        @(negedge clk);
        bus_reset = 1'b1;
        @(negedge clk);
        bus_reset = 1'b0;
        for (int i = 0; i < 8; i++) begin exp_p[i] = 0; exp_o[i] = 0; end
        chk_out("R9 target 2 cleared");
        do_sel(5);
        chk_out("R9 target 5 cleared");

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule